// File: doc/BRIEF.md
# Processor Status Trace Port

This block drives an external trace interface that has two parts: an 8-bit status bus and a sampling clock that runs at half the system clock rate. On every system clock the core hands it a 4-bit status code. The block pairs two consecutive codes into one two-cycle output window. The trace clock rises in the middle of each window, so an external probe can latch the bus on that rising edge with a full system cycle of margin on either side.

After reset the port stays silent, with the clock low and the bus at zero. It wakes on the first non-zero effective code seen while reset exception processing is flagged. A halted core is always reported as code 0xF. A quiet control bit freezes the clock and the bus for probes that do not need trace. Trigger logic elsewhere is not affected. The internal phase keeps running while quiet, so output resumes on the same window grid, at a window boundary.

Top module: `trc_port`

## Requirements
- R1: While running and not quiet, `trc_clk` is high for exactly one system cycle and then low for one, a period of two system cycles.
- R2: `trc_bus` changes only at clock edges after which `trc_clk` is low. `trc_clk` rises only at edges where `trc_bus` holds its value, which places the rise in the centre of the two-cycle window.
- R3: From reset until start-up, `trc_clk` is 0 and `trc_bus` is 0x00. Start-up happens at the first edge where `rst_proc` is 1 and the effective code is non-zero. A non-zero code with `rst_proc` at 0 does not start the port.
- R4: At the start-up edge, the bus loads 0x0 in bits [7:4] and the effective code in bits [3:0].
- R5: After start-up, each window's bus carries the code from the first cycle of the previous window in bits [3:0] and the code from its second cycle in bits [7:4].
- R6: When `halted` is 1, the effective code is 0xF, whatever `stat_code` holds.
- R7: If `quiet` is 1 at an edge, `trc_clk` is 0 and `trc_bus` is unchanged after that edge.
- R8: After `quiet` returns to 0, output resumes only at the next window boundary of the internal phase, which kept alternating while quiet. If that boundary is at the very next edge, the bus loads there.
- R9: Asserting `rst_n` low forces `trc_clk` to 0 and `trc_bus` to 0x00 at once and returns the port to the silent pre-start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stat_code | input | 4 | Status code from the core, one per cycle |
| halted | input | 1 | Core halted; forces effective code 0xF |
| quiet | input | 1 | Freeze trace clock and bus |
| rst_proc | input | 1 | Reset exception processing in progress |
| trc_clk | output | 1 | Half-rate trace sampling clock (registered) |
| trc_bus | output | 8 | Trace status bus: [3:0] earlier code, [7:4] later code |

## Verification
The assertions check the timing shape on every cycle. The trace clock never stays high for two cycles, the bus never changes while the clock is high, and a clock rise never coincides with a bus change. They also check that the port is silent before start-up and that a quiet cycle freezes both outputs. The bench scenarios are the only place the data path is checked: the order of the code pairs, the halt override, the start-up word, and the rule that the start needs `rst_proc`. The same holds for the phase alignment on resume, where a quiet release in mid-window must wait a cycle and a release at a boundary must load at once.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned TRC_CODE_W = 4;
  localparam logic [TRC_CODE_W-1:0] TRC_HALT_CODE = 4'hF;
endpackage

// File: rtl/trc_phase_gen.sv
module trc_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic quiet,
  output logic started,
  output logic start_fire,
  output logic win_load,
  output logic cap_en,
  output logic trc_clk
);
  logic started_q, started_d;
  logic ph_q, ph_d;
  logic live_q, live_d;
  logic clk_q, clk_d;

  always_comb begin
    started_d  = started_q;
    ph_d       = ph_q;
    live_d     = live_q;
    clk_d      = 1'b0;
    start_fire = 1'b0;
    win_load   = 1'b0;
    cap_en     = 1'b0;
    if (!started_q) begin
      if (start_req) begin
        start_fire = 1'b1;
        started_d  = 1'b1;
        ph_d       = 1'b0;
        live_d     = !quiet;
        win_load   = !quiet;
      end
    end else begin
      ph_d = !ph_q;
      if (!ph_q) begin
        cap_en = 1'b1;
        live_d = live_q && !quiet;
        clk_d  = live_d;
      end else begin
        win_load = !quiet;
        live_d   = !quiet;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      ph_q      <= 1'b0;
      live_q    <= 1'b0;
      clk_q     <= 1'b0;
    end else begin
      started_q <= started_d;
      ph_q      <= ph_d;
      live_q    <= live_d;
      clk_q     <= clk_d;
    end
  end

  assign started = started_q;
  assign trc_clk = clk_q;
endmodule

// File: rtl/trc_code_pair.sv
module trc_code_pair #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned BUS_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] eff_code,
  input  logic              start_fire,
  input  logic              win_load,
  input  logic              cap_en,
  output logic [BUS_W-1:0]  bus
);
  logic [CODE_W-1:0] pend_q, pend_d;
  logic [BUS_W-1:0]  bus_q, bus_d;

  always_comb begin
    pend_d = pend_q;
    bus_d  = bus_q;
    if (start_fire) begin
      pend_d = '0;
      if (win_load) bus_d = {{CODE_W{1'b0}}, eff_code};
    end else begin
      if (cap_en)   pend_d = eff_code;
      if (win_load) bus_d  = {eff_code, pend_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      bus_q  <= '0;
    end else begin
      pend_q <= pend_d;
      bus_q  <= bus_d;
    end
  end

  assign bus = bus_q;
endmodule

// File: rtl/trc_port.sv
module trc_port
  import trc_pkg::*;
#(
  parameter int unsigned CODE_W = TRC_CODE_W,
  parameter logic [CODE_W-1:0] HALT_CODE = TRC_HALT_CODE,
  localparam int unsigned BUS_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] stat_code,
  input  logic              halted,
  input  logic              quiet,
  input  logic              rst_proc,
  output logic              trc_clk,
  output logic [BUS_W-1:0]  trc_bus
);
  logic [CODE_W-1:0] eff_code;
  logic start_req, started, start_fire, win_load, cap_en;

  assign eff_code  = halted ? HALT_CODE : stat_code;
  assign start_req = rst_proc && (eff_code != '0);

  trc_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .quiet      (quiet),
    .started    (started),
    .start_fire (start_fire),
    .win_load   (win_load),
    .cap_en     (cap_en),
    .trc_clk    (trc_clk)
  );

  trc_code_pair #(.CODE_W(CODE_W)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_code   (eff_code),
    .start_fire (start_fire),
    .win_load   (win_load),
    .cap_en     (cap_en),
    .bus        (trc_bus)
  );
endmodule

// File: rtl/trc_port_chk.sv
module trc_port_chk #(
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             quiet,
  input logic             started,
  input logic             trc_clk,
  input logic [BUS_W-1:0] trc_bus
);
  AST_CLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    trc_clk |=> !trc_clk) else $error("clock high twice"); // R1

  AST_BUS_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trc_bus) |-> !trc_clk) else $error("bus moved with clock high"); // R2

  AST_RISE_CENTRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trc_clk) |-> $stable(trc_bus)) else $error("rise with bus change"); // R2

  AST_SILENT_PRESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!trc_clk && trc_bus == '0)) else $error("output before start"); // R3

  AST_QUIET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (!trc_clk && $stable(trc_bus))) else $error("quiet not frozen"); // R7
endmodule

bind trc_port trc_port_chk #(.BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .quiet   (quiet),
  .started (started),
  .trc_clk (trc_clk),
  .trc_bus (trc_bus)
);

// File: tb/tb_trc_port.sv
`timescale 1ns/1ps
module tb_trc_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] stat_code;
  logic       halted, quiet, rst_proc;
  logic       trc_clk;
  logic [7:0] trc_bus;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trc_port dut (
    .clk(clk), .rst_n(rst_n), .stat_code(stat_code), .halted(halted),
    .quiet(quiet), .rst_proc(rst_proc), .trc_clk(trc_clk), .trc_bus(trc_bus)
  );

  // {code[15:12], halted[11], quiet[10], rst_proc[9], exp_clk[8], exp_bus[7:0]}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // zero code in reset processing: idle
    {4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // non-zero without rst_proc: idle
    {4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0C},  // start-up word
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0C},
    {4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21},
    {4'h3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h21},
    {4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF3},  // halt override
    {4'h5, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF3},
    {4'h6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6F},
    {4'h7, 1'b0, 1'b1, 1'b0, 1'b0, 8'h6F},  // quiet
    {4'h8, 1'b0, 1'b1, 1'b0, 1'b0, 8'h6F},
    {4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6F},  // released mid-window: wait
    {4'hA, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA9},  // boundary: resume
    {4'hB, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA9},
    {4'hD, 1'b0, 1'b0, 1'b0, 1'b0, 8'hDB},
    {4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDB}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1:    return "R3";
      2:       return "R4";
      6, 7, 8: return "R6";
      9, 10:   return "R7";
      11, 12:  return "R8";
      3, 5, 13, 15: return "R1";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic exp_c, logic [7:0] exp_b);
    n_chk++;
    if (trc_clk !== exp_c || trc_bus !== exp_b) begin
      n_fail++;
      $display("FAIL %s: clk=%0b bus=%02h expected clk=%0b bus=%02h",
               req, trc_clk, trc_bus, exp_c, exp_b);
    end
  endtask

  task automatic drive(logic [3:0] c, logic h, logic q, logic rp);
    stat_code = c; halted = h; quiet = q; rst_proc = rp;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(4'h0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R9", 1'b0, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15:12], VEC[i][11], VEC[i][10], VEC[i][9]);
      @(negedge clk);
      check(vec_req(i), VEC[i][8], VEC[i][7:0]);
    end

    // R9: asynchronous reset mid-run
    drive(4'h3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: port silent again after reset, code non-zero but no rst_proc
    @(negedge clk);
    check("R3", 1'b0, 8'h00);

    // R6 and R4: start from halted with code 0
    drive(4'h0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R6", 1'b0, 8'h0F);
    // R7: quiet on first half of window
    drive(4'h3, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R7", 1'b0, 8'h0F);
    // R8: release exactly at a boundary loads at once
    drive(4'h4, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8", 1'b0, 8'h43);
    drive(4'h5, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2", 1'b1, 8'h43);
    drive(4'h6, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R5", 1'b0, 8'h65);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule